// File: doc/BRIEF.md
# Serial Receiver Control and Status

This block is the receive half of an asynchronous serial port. A single 8-bit control/status register selects the port enable, the frame length (8 or 9 data bits) and the arming source, and reports the framing and overrun flags. It also reports the ninth data bit of the byte at the head of the receive buffer. A frame receiver samples the serial line at mid-bit using a 16x oversampling tick from an external baud generator. Completed frames go into a two-entry receive buffer. Each entry holds the data byte, its ninth bit and its framing result.

Software arms the receiver with the continuous-receive enable. A one-shot receive enable serves the clocked-master configuration, which the `one_shot_mode_i` input selects. That enable clears itself after one frame. Continuous receive overrides it. A read strobe pops the head of the buffer. The framing flag and the ninth bit in the register always describe the entry now at the head.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset, `reg_rdata_o` reads 0x00 and `data_valid_o` is 0.
- R2: Register bit 3 always reads 0. Writes to bits 3, 2, 1 and 0 have no effect, so writing 0xFF reads back 0xF0 while the buffer is empty and no overrun is pending.
- R3: When the port enable (bit 7) is 0, frames on `rx_i` are ignored and nothing enters the buffer.
- R4: With bit 6 = 0, a frame consists of one low start bit, 8 data bits sent least significant bit first, and a stop bit. The received byte appears on `data_o` with `data_valid_o` = 1. Register bit 0 reads 0 for such an entry.
- R5: With bit 6 = 1, a ninth data bit follows the 8 data bits. Register bit 0 shows the ninth bit of the head entry.
- R6: A stop bit that samples low marks the entry with a framing error. Register bit 2 shows that mark for the head entry, and it changes when a read strobe advances the head.
- R7: A low pulse on `rx_i` that is high again at the middle of the start bit is rejected and yields no entry.
- R8: The buffer holds two entries. A frame that completes while both entries are full is dropped and sets the overrun flag (bit 1). While that flag is set, no further frame is accepted.
- R9: The overrun flag stays set through reads. It clears only on a register write with bit 4 = 0. That write also returns the receiver to idle, and the buffered entries stay readable.
- R10: The one-shot enable (bit 5) arms the receiver only while `one_shot_mode_i` = 1. There it clears itself after one frame. With `one_shot_mode_i` = 0 it is ignored and keeps its value.
- R11: When bits 5 and 4 are both set, continuous receive applies. Bit 5 is not cleared, and frames keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control/status register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data: {enable, nine, one-shot, continuous, 0, framing, overrun, ninth bit} |
| one_shot_mode_i | input | 1 | Selects the configuration in which the one-shot enable arms the receiver |
| rx_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| data_rd_i | input | 1 | Read strobe that pops the head entry |
| data_o | output | DATA_W | Data byte of the head entry, 0 when empty |
| data_valid_o | output | 1 | Buffer holds at least one entry |

## Verification
The assertions assume that register writes are the only path to the enable and flag bits. They also assume that no frame can complete unless the receiver is armed, so disabling or an overrun freezes the buffer apart from reads. The stimulus keeps `rx_i` changes aligned to whole bit times of 16 ticks, with at least half a bit of idle line between frames. Register writes happen only between frames, except for the deliberate overrun sequence. Randomized byte values and frame lengths are drawn from a fixed seed. Directed cases cover glitches, stop-bit errors, buffer overflow and the one-shot clearing rules.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned BIT_EN     = 7;
  localparam int unsigned BIT_NINE   = 6;
  localparam int unsigned BIT_SINGLE = 5;
  localparam int unsigned BIT_CONT   = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              nine_i,
  input  logic              rx_i,
  input  logic              tick_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              ferr_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W:0]  sh_q;
  logic             nine_q, ferr_q, done_q;
  logic [1:0]       sync_q;
  logic             rx_s;
  logic [IDX_W-1:0] last_idx;

  assign rx_s     = sync_q[1];
  assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (!arm_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            nine_q  <= nine_i;
          end
          ST_START: if (cnt_q == HALF) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx_s ? ST_IDLE : ST_DATA;  // glitch rejection
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (cnt_q == LAST) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[DATA_W:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx) state_q <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_STOP: if (cnt_q == LAST) begin
            cnt_q   <= '0;
            ferr_q  <= !rx_s;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // 8-bit frames leave the byte one position higher in the shifter
  assign data_o  = nine_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
  assign ninth_o = nine_q & sh_q[DATA_W];
  assign ferr_o  = ferr_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rx_entry_fifo.sv
module rx_entry_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop_ok  = pop_i & ~empty_o;
  assign push_ok = push_i & (~full_o | pop_ok);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              one_shot_mode_i,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o
);
  localparam int unsigned ENT_W = DATA_W + 2;

  logic en_q, nine_q, single_q, cont_q, oerr_q;
  logic cont_off_wr, arm, done, done_eff;
  logic [DATA_W-1:0] rx_data;
  logic rx_ninth, rx_ferr;
  logic [ENT_W-1:0] head;
  logic full, empty, pop, overrun;
  logic unused_w;

  assign unused_w    = ^reg_wdata_i[3:0];
  assign cont_off_wr = reg_we_i & ~reg_wdata_i[BIT_CONT];
  // continuous wins; one-shot arms only in its mode; overrun inhibits
  assign arm = en_q & ~oerr_q & (cont_q | (one_shot_mode_i & single_q)) & ~cont_off_wr;

  rx_frame_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .nine_i  (nine_q),
    .rx_i    (rx_i),
    .tick_i  (tick_i),
    .done_o  (done),
    .data_o  (rx_data),
    .ninth_o (rx_ninth),
    .ferr_o  (rx_ferr)
  );

  assign done_eff = done & arm;
  assign pop      = data_rd_i & ~empty;
  assign overrun  = done_eff & full & ~pop;

  rx_entry_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (done_eff),
    .pop_i   (data_rd_i),
    .wdata_i ({rx_ferr, rx_ninth, rx_data}),
    .rdata_o (head),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      nine_q   <= 1'b0;
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      oerr_q   <= 1'b0;
    end else begin
      if (reg_we_i) begin
        en_q     <= reg_wdata_i[BIT_EN];
        nine_q   <= reg_wdata_i[BIT_NINE];
        single_q <= reg_wdata_i[BIT_SINGLE];
        cont_q   <= reg_wdata_i[BIT_CONT];
      end else if (done_eff & one_shot_mode_i & single_q & ~cont_q) begin
        single_q <= 1'b0;
      end
      if (cont_off_wr)  oerr_q <= 1'b0;
      else if (overrun) oerr_q <= 1'b1;
    end
  end

  assign data_valid_o = ~empty;
  assign data_o       = empty ? '0 : head[DATA_W-1:0];
  assign reg_rdata_o  = {en_q, nine_q, single_q, cont_q, 1'b0,
                         ~empty & head[DATA_W+1], oerr_q, ~empty & head[DATA_W]};
endmodule

// File: rtl/uart_rx_ctrl_chk.sv
module uart_rx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       one_shot_mode_i,
  input logic       data_rd_i,
  input logic [7:0] data_o,
  input logic       data_valid_o
);
  assert_disabled_no_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[7] && !data_valid_o |=> !data_valid_o);

  assert_ferr_needs_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> !reg_rdata_o[2]);

  assert_overrun_freezes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1] && !reg_we_i && !data_rd_i |=> $stable(data_o) && $stable(data_valid_o));

  assert_overrun_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1] && !(reg_we_i && !reg_wdata_i[4]) |=> reg_rdata_o[1]);

  assert_overrun_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_wdata_i[4] |=> !reg_rdata_o[1]);

  assert_one_shot_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[5] && !one_shot_mode_i && !reg_we_i |=> reg_rdata_o[5]);
endmodule

bind uart_rx_ctrl uart_rx_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .one_shot_mode_i (one_shot_mode_i),
  .data_rd_i       (data_rd_i),
  .data_o          (data_o),
  .data_valid_o    (data_valid_o)
);

// File: tb/uart_rx_ctrl_tb.sv
`timescale 1ns/1ps
module uart_rx_ctrl_tb;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every other clock

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       one_shot = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] dout;
  logic       valid;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_rx_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .one_shot_mode_i(one_shot), .rx_i(rx), .tick_i(tick),
    .data_rd_i(rd), .data_o(dout), .data_valid_o(valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [8:0] d);
    return d[7:0];
  endfunction

  function automatic logic exp_ninth(input logic [8:0] d, input logic nine);
    return nine & d[8];
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic stop);
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rx = 1'b1;
    repeat (BIT_CLKS / 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", 16'(rdata), 16'h00);
    chk("R1 reset valid", 16'(valid), 16'h0);

    wr(8'hFF);
    chk("R2 read-only bits", 16'(rdata), 16'hF0);

    wr(8'h90);
    send(9'h0A5, 1'b0, 1'b1);
    chk("R4 data", 16'(dout), 16'hA5);
    chk("R4 valid", 16'(valid), 16'h1);
    chk("R4 status", 16'(rdata), 16'h90);
    pop();
    chk("R4 empty after pop", 16'(valid), 16'h0);

    wr(8'hD0);
    send(9'h13C, 1'b1, 1'b1);
    chk("R5 data", 16'(dout), 16'h3C);
    chk("R5 ninth bit", 16'(rdata), 16'hD1);
    pop();

    wr(8'h90);
    send(9'h011, 1'b0, 1'b0);
    send(9'h022, 1'b0, 1'b1);
    chk("R6 ferr head", 16'(rdata[2]), 16'h1);
    chk("R6 data head", 16'(dout), 16'h11);
    pop();
    chk("R6 ferr refreshed", 16'(rdata[2]), 16'h0);
    chk("R6 next data", 16'(dout), 16'h22);
    pop();

    @(negedge clk); rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (400) @(negedge clk);
    chk("R7 glitch rejected", 16'(valid), 16'h0);
    send(9'h05A, 1'b0, 1'b1);
    chk("R7 frame after glitch", 16'(dout), 16'h5A);
    pop();

    send(9'h001, 1'b0, 1'b1);
    send(9'h002, 1'b0, 1'b1);
    send(9'h003, 1'b0, 1'b1);
    chk("R8 overrun set", 16'(rdata[1]), 16'h1);
    send(9'h004, 1'b0, 1'b1);
    chk("R8 head kept", 16'(dout), 16'h01);
    pop();
    chk("R9 overrun survives read", 16'(rdata[1]), 16'h1);
    chk("R8 second entry", 16'(dout), 16'h02);
    wr(8'h80);
    chk("R9 overrun cleared", 16'(rdata), 16'h80);
    chk("R9 data kept", 16'(dout), 16'h02);
    pop();
    chk("R8 dropped frames", 16'(valid), 16'h0);

    wr(8'h10);
    send(9'h077, 1'b0, 1'b1);
    chk("R3 disabled ignores line", 16'(valid), 16'h0);
    chk("R3 status", 16'(rdata), 16'h10);

    one_shot = 1'b0;
    wr(8'hA0);
    send(9'h033, 1'b0, 1'b1);
    chk("R10 ignored outside one-shot mode", 16'(valid), 16'h0);
    chk("R10 bit kept", 16'(rdata[5]), 16'h1);
    one_shot = 1'b1;
    wr(8'hA0);
    send(9'h033, 1'b0, 1'b1);
    chk("R10 one-shot data", 16'(dout), 16'h33);
    chk("R10 self-clear", 16'(rdata), 16'h80);
    pop();
    send(9'h044, 1'b0, 1'b1);
    chk("R10 no second frame", 16'(valid), 16'h0);

    wr(8'hB0);
    send(9'h055, 1'b0, 1'b1);
    chk("R11 one-shot kept", 16'(rdata), 16'hB0);
    pop();
    send(9'h066, 1'b0, 1'b1);
    chk("R11 keeps receiving", 16'(dout), 16'h66);
    pop();

    one_shot = 1'b0;
    for (int k = 0; k < 20; k++) begin
      logic [8:0] d;
      logic       nine;
      d    = 9'($urandom);
      nine = 1'($urandom);
      wr({1'b1, nine, 6'b010000});
      send(d, nine, 1'b1);
      chk("R4 random data", 16'(dout), 16'(exp_byte(d)));
      chk("R5 random ninth", 16'(rdata[0]), 16'(exp_ninth(d, nine)));
      pop();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule